// File: doc/BRIEF.md
# ADC Result Holding Registers with Read Lock

This block keeps the latest conversion result of an analog-to-digital converter and presents it to a CPU as two byte-wide registers on a simple read/write bus. The converter core delivers a one-cycle `done_i` strobe together with a 10-bit value. The block stores the raw value. Each bus read then formats it, either right-justified (the default) or left-justified, according to an adjust-left control bit.

A read of the low byte locks the stored result until the high byte is read. This guarantees that software reading low then high gets both bytes from one conversion. A result that arrives while locked is discarded. The completion flag still rises for it. With left-justification, software that needs only 8 bits may read the high byte alone; such a read never locks.

The completion flag is cleared by writing a one to its control bit or by pulsing the interrupt acknowledge input.

Top module: `adcr_result_regs`

## Requirements
- R1: After reset, the stored result is 0, the adjust-left bit is 0, the lock is clear, `irq_flag_o` is 0 and `rdata_o` is 0.
- R2: Register addresses are low byte = 0, high byte = 1, control = 2. A read presents its data on `rdata_o` from the clock edge that samples `rd_en_i`. Control reads return bit 0 = adjust-left and bit 1 = completion flag, with the other bits 0.
- R3: With adjust-left = 0, the low byte is result[7:0] and the high byte is {6'b0, result[9:8]}.
- R4: With adjust-left = 1, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R5: A change of adjust-left reformats the already stored result on the next read, with no new conversion.
- R6: A low-byte read locks the registers. A `done_i` while locked, or in the same cycle as a low-byte read, leaves the stored result unchanged.
- R7: A high-byte read clears the lock. A high-byte read without a preceding low-byte read leaves the lock clear, so a later conversion is stored.
- R8: When unlocked and with no low-byte read in the same cycle, `done_i` stores `res_i` at that edge.
- R9: Every `done_i` sets `irq_flag_o` on the next edge, including one whose result was discarded.
- R10: Writing a 1 to control bit 1, or asserting `irq_ack_i`, clears the flag. A `done_i` in the same cycle wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register select |
| rd_en_i | input | 1 | Bus read strobe |
| wr_en_i | input | 1 | Bus write strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Registered read data |
| done_i | input | 1 | Conversion complete strobe |
| res_i | input | 10 | Conversion result |
| irq_ack_i | input | 1 | Interrupt serviced, clears flag |
| irq_flag_o | output | 1 | Completion flag |

## Verification
The bench locks the registers with a low-byte read and then delivers a new conversion. A design that did not lock, or locked only one byte, would return the new high byte paired with the old low byte. A repeated low/high read pair would also return the new value instead of the old one. The bench lands `done_i` in the same cycle as a low-byte read and as an acknowledge. A design that let the strobe through, or let the clear win, would show a changed result or a cleared flag. The bench also flips adjust-left over a stored result, and reads the high byte alone before a new conversion, to catch formatting tied to capture time and a lock set by the wrong byte.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2
  } reg_sel_e;
  localparam int CTRL_ADJ_BIT  = 0;
  localparam int CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/adcr_lock.sv
module adcr_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_rd_i,
  input  logic hi_rd_i,
  input  logic done_i,
  output logic locked_o,
  output logic capture_o
);
  logic locked_q;

  // a low read in the done cycle also blocks, so the pair stays coherent
  assign capture_o = done_i & ~locked_q & ~lo_rd_i;
  assign locked_o  = locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      locked_q <= 1'b0;
    else if (lo_rd_i) locked_q <= 1'b1;
    else if (hi_rd_i) locked_q <= 1'b0;
  end
endmodule

// File: rtl/adcr_flag.sv
module adcr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic sw_clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (set_i)             flag_q <= 1'b1;
    else if (ack_i || sw_clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/adcr_fmt.sv
module adcr_fmt #(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              left_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  localparam int HI_W  = RES_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic [DATA_W-1:0] r_lo, r_hi, l_lo, l_hi;

  assign r_lo = res_i[DATA_W-1:0];
  assign r_hi = {{PAD_W{1'b0}}, res_i[RES_W-1:DATA_W]};
  assign l_hi = res_i[RES_W-1 -: DATA_W];
  assign l_lo = {res_i[HI_W-1:0], {PAD_W{1'b0}}};

  assign lo_o = left_i ? l_lo : r_lo;
  assign hi_o = left_i ? l_hi : r_hi;
endmodule

// File: rtl/adcr_result_regs.sv
module adcr_result_regs
  import adcr_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              done_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              irq_ack_i,
  output logic              irq_flag_o
);
  logic [RES_W-1:0]  res_q;
  logic              adj_q;
  logic [DATA_W-1:0] rdata_q, rd_mux, fmt_lo, fmt_hi;
  logic              lo_rd, hi_rd, ctrl_wr, locked, capture, sw_clr;

  assign lo_rd   = rd_en_i && (addr_i == REG_LO);
  assign hi_rd   = rd_en_i && (addr_i == REG_HI);
  assign ctrl_wr = wr_en_i && (addr_i == REG_CTRL);
  assign sw_clr  = ctrl_wr && wdata_i[CTRL_FLAG_BIT];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  adcr_lock u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lo_rd_i   (lo_rd),
    .hi_rd_i   (hi_rd),
    .done_i    (done_i),
    .locked_o  (locked),
    .capture_o (capture)
  );

  adcr_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (done_i),
    .ack_i    (irq_ack_i),
    .sw_clr_i (sw_clr),
    .flag_o   (irq_flag_o)
  );

  adcr_fmt #(.RES_W(RES_W), .DATA_W(DATA_W)) u_fmt (
    .res_i  (res_q),
    .left_i (adj_q),
    .lo_o   (fmt_lo),
    .hi_o   (fmt_hi)
  );

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      REG_LO:   rd_mux = fmt_lo;
      REG_HI:   rd_mux = fmt_hi;
      REG_CTRL: begin
        rd_mux[CTRL_ADJ_BIT]  = adj_q;
        rd_mux[CTRL_FLAG_BIT] = irq_flag_o;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      adj_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (capture) res_q   <= res_i;
      if (ctrl_wr) adj_q   <= wdata_i[CTRL_ADJ_BIT];
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/adcr_checker.sv
module adcr_checker #(
  parameter int RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic [1:0]       addr_i,
  input logic             done_i,
  input logic [RES_W-1:0] res_i,
  input logic             irq_flag_o,
  input logic             locked,
  input logic [RES_W-1:0] res_q
);
  // R6
  lock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd0) |=> locked);
  // R6
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (locked || (rd_en_i && addr_i == 2'd0))) |=> $stable(res_q));
  // R7
  unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd1) |=> !locked);
  // R8
  store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !locked && !(rd_en_i && addr_i == 2'd0)) |=> res_q == $past(res_i));
  // R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> irq_flag_o);
endmodule

bind adcr_result_regs adcr_checker #(.RES_W(RES_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .done_i     (done_i),
  .res_i      (res_i),
  .irq_flag_o (irq_flag_o),
  .locked     (locked),
  .res_q      (res_q)
);

// File: tb/tb_adcr_result_regs.sv
module tb_adcr_result_regs;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       rd_en_i = 1'b0, wr_en_i = 1'b0, done_i = 1'b0, irq_ack_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [9:0] res_i = '0;
  logic [7:0] rdata_o;
  logic       irq_flag_o;

  int n_chk = 0, n_fail = 0;
  logic mon_v = 1'b0;

  typedef struct {
    logic [7:0] d;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk_i = ~clk_i;

  adcr_result_regs dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .done_i(done_i),
    .res_i(res_i), .irq_ack_i(irq_ack_i), .irq_flag_o(irq_flag_o)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: read data is valid at the negedge after the sampling edge
  always @(posedge clk_i) mon_v <= rd_en_i;
  always @(negedge clk_i) begin
    if (mon_v) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: read without expectation, actual %02h expected none", rdata_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rdata_o, e.d, e.tag);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.d = exp; e.tag = tag;
    exp_q.push_back(e);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic conv(input logic [9:0] v);
    res_i = v; done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check(rdata_o, 8'h00, "R1 rdata");
    check({7'd0, irq_flag_o}, 8'h00, "R1 flag");
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(2'd0, 8'h00, "R1 lo");
    rd(2'd1, 8'h00, "R1 hi");
    rd(2'd2, 8'h00, "R1 R2 ctrl");

    // R3 right-justified, R9 flag
    conv(10'h2A5);
    check({7'd0, irq_flag_o}, 8'h01, "R9 flag set");
    rd(2'd0, 8'hA5, "R3 lo");
    rd(2'd1, 8'h02, "R3 hi");
    rd(2'd2, 8'h02, "R2 ctrl flag");

    // R4 R5 left-justify existing result
    wr(2'd2, 8'h01);
    rd(2'd1, 8'hA9, "R4 R5 hi");
    rd(2'd0, 8'h40, "R4 R5 lo");
    rd(2'd1, 8'hA9, "R7 hi unlock");
    // R7 high-only read, no lock: new result stored
    rd(2'd1, 8'hA9, "R7 hi only");
    conv(10'h155);
    rd(2'd1, 8'h55, "R7 R8 stored after hi-only");

    // R10 software clear
    wr(2'd2, 8'h03);
    check({7'd0, irq_flag_o}, 8'h00, "R10 sw clear");

    // R6 lock drops result, R9 flag still set
    rd(2'd0, 8'h40, "R6 lo lock");
    conv(10'h3FF);
    check({7'd0, irq_flag_o}, 8'h01, "R9 flag on drop");
    rd(2'd1, 8'h55, "R6 hi old");
    rd(2'd0, 8'h40, "R6 lo dropped");
    rd(2'd1, 8'h55, "R6 hi dropped");
    // R8 unlocked store
    conv(10'h3FF);
    rd(2'd1, 8'hFF, "R8 hi");
    rd(2'd0, 8'hC0, "R8 lo");
    rd(2'd1, 8'hFF, "R8 hi pair");

    // R10 ack clear, then done wins over ack
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
    check({7'd0, irq_flag_o}, 8'h00, "R10 ack clear");
    irq_ack_i = 1'b1; res_i = 10'h0F0; done_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0; done_i = 1'b0;
    check({7'd0, irq_flag_o}, 8'h01, "R10 set wins");

    // R6 done in the same cycle as a low read is dropped
    wr(2'd2, 8'h00);
    rd(2'd0, 8'hF0, "R3 lo");
    rd(2'd1, 8'h00, "R3 hi");
    begin
      exp_t e;
      e.d = 8'hF0; e.tag = "R6 same-cycle lo";
      exp_q.push_back(e);
      addr_i = 2'd0; rd_en_i = 1'b1; res_i = 10'h001; done_i = 1'b1;
      @(negedge clk_i);
      rd_en_i = 1'b0; done_i = 1'b0;
    end
    rd(2'd1, 8'h00, "R6 same-cycle hi");
    rd(2'd0, 8'hF0, "R6 same-cycle kept");
    rd(2'd1, 8'h00, "R6 same-cycle kept hi");
    @(negedge clk_i);

    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2: actual %0d pending reads expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule